// File: doc/BRIEF.md
# Thread Block Dispatch Unit

This unit sits between a kernel launch source and a set of streaming multiprocessor slots. A launch request describes a grid of thread blocks (two grid dimensions), the three dimensions of each block, and how many registers every thread needs. The request is screened once when it is accepted. A block that would hold more threads than the per-block limit, or whose register demand (threads per block times registers per thread) would exceed one slot's register file, is refused with a one-cycle error pulse. A request with any zero dimension is also refused.

An accepted kernel is walked block by block. Blocks are taken in grid order, with the x index changing fastest. Each block is placed whole on one free multiprocessor slot. The slot is chosen round-robin, starting just after the slot that was last used. The block is then issued as a stream of warps: one descriptor per handshake, in ascending warp order. Each descriptor carries the slot, the block coordinates, the warp number, the linear thread ID of its lane 0, and an active-lane mask. Lane i of a warp has linear ID equal to the base ID plus i, and the linear ID of a thread at index (x, y, z) is x + y*Dx + z*Dx*Dy. A slot holds one resident block. It stays occupied until the consumer pulses that slot's done line. When every slot is occupied, the next block waits.

Top module: `blk_dispatch`

## Requirements
- R1: A launch whose thread count Dx*Dy*Dz exceeds 512, or that has any zero block or grid dimension, is refused. `launch_err` goes high for exactly the one cycle after the handshake, and no warp is issued.
- R2: A launch whose register demand (registers per thread times threads per block) exceeds 8192 is refused in the same way. A demand of exactly 8192 is accepted.
- R3: A block of T threads produces ceil(T/32) warps. Every warp has all 32 mask bits set except the last warp, whose mask has bits 0 to (T mod 32)-1 set when T is not a multiple of 32. Mask bit i stands for lane i.
- R4: `warp_tid` equals the warp number times 32. It is the linear thread ID of lane 0.
- R5: The warps of a block are issued in order, starting at warp 0 and rising by one per accepted handshake. While `warp_valid` is high and `warp_ready` is low, every warp field holds its value.
- R6: Blocks are issued in grid order: `warp_blk_x` counts from 0 to Gx-1, then `warp_blk_y` advances.
- R7: Every warp of one block carries the same `warp_sm`.
- R8: A block goes to the first free slot found by searching upward, with wraparound, from the slot after the last one assigned. After reset the search starts at slot 0.
- R9: A slot that is assigned a block stays occupied until its `sm_done` bit is pulsed. After the pulse, a waiting block can take that slot on the next cycle, so its first warp appears two cycles after the pulse.
- R10: `launch_ready` is low from the accepted launch until the last warp of the last block has been taken. It is high on the cycle after that.
- R11: `launch_err` is never high for two cycles in a row, and only follows a launch handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| launch_valid | input | 1 | Launch request present |
| launch_ready | output | 1 | Unit idle and able to take a launch |
| launch_grid_x | input | GRID_W | Blocks along grid x |
| launch_grid_y | input | GRID_W | Blocks along grid y |
| launch_dim_x | input | DIM_W | Threads along block x |
| launch_dim_y | input | DIM_W | Threads along block y |
| launch_dim_z | input | DIM_W | Threads along block z |
| launch_regs | input | RPT_W | Registers per thread |
| launch_err | output | 1 | One-cycle pulse for a refused launch |
| sm_done | input | NUM_SM | Per-slot completion pulse |
| warp_valid | output | 1 | Warp descriptor present |
| warp_ready | input | 1 | Consumer takes the descriptor |
| warp_sm | output | SM_W | Slot the block is pinned to |
| warp_blk_x | output | GRID_W | Block x coordinate |
| warp_blk_y | output | GRID_W | Block y coordinate |
| warp_id | output | WID_W | Warp number inside the block |
| warp_tid | output | THR_W | Linear thread ID of lane 0 |
| warp_mask | output | WARP_W | Active-lane mask |

## Verification
The directed launches use three block shapes. A 1-D block of 40 threads tests the partial last mask. A 3-D block of exactly 32 threads separates correct linearization from a single full warp. A 512-thread block at exactly 8192 registers sits on both admission limits. Refusals at 513 threads, at 8448 registers and with a zero dimension separate the size check from the budget check and from the dimension check. Random block shapes and grid sizes, combined with random back-pressure and random completion pulses, test the round-robin slot choice against an independent occupancy model. A directed case fills every slot, then frees a slot that is not next in the round-robin order. This shows that a waiting block takes exactly the freed slot, and does so on the second cycle after the pulse.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PICK  = 2'd1,
    ST_ISSUE = 2'd2
  } tbd_state_e;
endpackage

// File: rtl/tbd_admit.sv
module tbd_admit #(
  parameter int DIM_W       = 10,
  parameter int GRID_W      = 6,
  parameter int RPT_W       = 8,
  parameter int THR_W       = 10,
  parameter int MAX_THREADS = 512,
  parameter int REG_BUDGET  = 8192
) (
  input  logic [GRID_W-1:0] grid_x,
  input  logic [GRID_W-1:0] grid_y,
  input  logic [DIM_W-1:0]  dim_x,
  input  logic [DIM_W-1:0]  dim_y,
  input  logic [DIM_W-1:0]  dim_z,
  input  logic [RPT_W-1:0]  regs,
  output logic              accept,
  output logic [THR_W-1:0]  threads
);
  localparam int PROD_W = 3 * DIM_W;
  localparam int DEM_W  = PROD_W + RPT_W;

  logic [PROD_W-1:0] prod;
  logic [DEM_W-1:0]  demand;
  logic              size_ok, budget_ok;

  // full-width product so oversize shapes cannot alias into range
  assign prod      = PROD_W'(dim_x) * PROD_W'(dim_y) * PROD_W'(dim_z);
  assign demand    = DEM_W'(prod) * DEM_W'(regs);
  assign size_ok   = (prod != '0) && (prod <= PROD_W'(MAX_THREADS));
  assign budget_ok = (demand <= DEM_W'(REG_BUDGET));
  assign accept    = size_ok && budget_ok && (grid_x != '0) && (grid_y != '0);
  assign threads   = THR_W'(prod);
endmodule

// File: rtl/tbd_rr_pick.sv
module tbd_rr_pick #(
  parameter int N   = 3,
  parameter int IDW = 2
) (
  input  logic [N-1:0]   busy,
  input  logic [IDW-1:0] last,
  output logic           found,
  output logic [IDW-1:0] pick
);
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(last) + k;
      if (idx >= N) idx = idx - N;
      if (!found && !busy[idx]) begin
        found = 1'b1;
        pick  = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/tbd_lane_mask.sv
module tbd_lane_mask #(
  parameter int WARP_W = 32,
  parameter int THR_W  = 10,
  parameter int WID_W  = 4
) (
  input  logic [THR_W-1:0]  threads,
  input  logic [WID_W-1:0]  widx,
  output logic [WARP_W-1:0] mask
);
  localparam int LG = $clog2(WARP_W);

  logic [THR_W:0] base, rem;
  assign base = (THR_W+1)'(widx) << LG;
  assign rem  = {1'b0, threads} - base;

  for (genvar i = 0; i < WARP_W; i++) begin : g_lane
    assign mask[i] = (rem > (THR_W+1)'(i));
  end
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch #(
  parameter int NUM_SM      = 3,
  parameter int GRID_W      = 6,
  parameter int DIM_W       = 10,
  parameter int RPT_W       = 8,
  parameter int WARP_W      = 32,
  parameter int MAX_THREADS = 512,
  parameter int REG_BUDGET  = 8192,
  localparam int SM_W   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  localparam int THR_W  = $clog2(MAX_THREADS + 1),
  localparam int LG_WARP = $clog2(WARP_W),
  localparam int MAX_WARPS = (MAX_THREADS + WARP_W - 1) / WARP_W,
  localparam int WID_W  = (MAX_WARPS > 1) ? $clog2(MAX_WARPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_valid,
  output logic              launch_ready,
  input  logic [GRID_W-1:0] launch_grid_x,
  input  logic [GRID_W-1:0] launch_grid_y,
  input  logic [DIM_W-1:0]  launch_dim_x,
  input  logic [DIM_W-1:0]  launch_dim_y,
  input  logic [DIM_W-1:0]  launch_dim_z,
  input  logic [RPT_W-1:0]  launch_regs,
  output logic              launch_err,
  input  logic [NUM_SM-1:0] sm_done,
  output logic              warp_valid,
  input  logic              warp_ready,
  output logic [SM_W-1:0]   warp_sm,
  output logic [GRID_W-1:0] warp_blk_x,
  output logic [GRID_W-1:0] warp_blk_y,
  output logic [WID_W-1:0]  warp_id,
  output logic [THR_W-1:0]  warp_tid,
  output logic [WARP_W-1:0] warp_mask
);
  import tbd_pkg::*;

  tbd_state_e        state_q;
  logic [GRID_W-1:0] gx_q, gy_q, bx_q, by_q;
  logic [THR_W-1:0]  thr_q;
  logic [WID_W-1:0]  wlast_q, w_q, w_sel;
  logic [SM_W-1:0]   sm_q, last_q, pick;
  logic [NUM_SM-1:0] busy_q, busy_d;
  logic [WARP_W-1:0] mask_q, mask_nxt;
  logic              err_q, found, adm_ok;
  logic [THR_W-1:0]  adm_thr;

  tbd_admit #(
    .DIM_W(DIM_W), .GRID_W(GRID_W), .RPT_W(RPT_W), .THR_W(THR_W),
    .MAX_THREADS(MAX_THREADS), .REG_BUDGET(REG_BUDGET)
  ) u_admit (
    .grid_x(launch_grid_x), .grid_y(launch_grid_y),
    .dim_x(launch_dim_x), .dim_y(launch_dim_y), .dim_z(launch_dim_z),
    .regs(launch_regs), .accept(adm_ok), .threads(adm_thr)
  );

  tbd_rr_pick #(.N(NUM_SM), .IDW(SM_W)) u_pick (
    .busy(busy_q), .last(last_q), .found(found), .pick(pick)
  );

  // mask for the warp that becomes current after this cycle
  assign w_sel = (state_q == ST_PICK) ? '0 : w_q + WID_W'(1);

  tbd_lane_mask #(.WARP_W(WARP_W), .THR_W(THR_W), .WID_W(WID_W)) u_mask (
    .threads(thr_q), .widx(w_sel), .mask(mask_nxt)
  );

  // done releases take effect at this edge; the picker saw busy_q
  always_comb begin
    busy_d = busy_q & ~sm_done;
    if (state_q == ST_PICK && found) busy_d = busy_d | (NUM_SM'(1) << pick);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      gx_q    <= '0;
      gy_q    <= '0;
      bx_q    <= '0;
      by_q    <= '0;
      thr_q   <= '0;
      wlast_q <= '0;
      w_q     <= '0;
      sm_q    <= '0;
      last_q  <= SM_W'(NUM_SM - 1);
      busy_q  <= '0;
      mask_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (launch_valid) begin
            if (adm_ok) begin
              gx_q    <= launch_grid_x;
              gy_q    <= launch_grid_y;
              thr_q   <= adm_thr;
              wlast_q <= WID_W'((adm_thr - THR_W'(1)) >> LG_WARP);
              bx_q    <= '0;
              by_q    <= '0;
              state_q <= ST_PICK;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_PICK: begin
          if (found) begin
            sm_q    <= pick;
            last_q  <= pick;
            w_q     <= '0;
            mask_q  <= mask_nxt;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (warp_ready) begin
            if (w_q == wlast_q) begin
              if (bx_q == gx_q - GRID_W'(1)) begin
                bx_q <= '0;
                if (by_q == gy_q - GRID_W'(1)) begin
                  state_q <= ST_IDLE;
                end else begin
                  by_q    <= by_q + GRID_W'(1);
                  state_q <= ST_PICK;
                end
              end else begin
                bx_q    <= bx_q + GRID_W'(1);
                state_q <= ST_PICK;
              end
            end else begin
              w_q    <= w_q + WID_W'(1);
              mask_q <= mask_nxt;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign launch_ready = (state_q == ST_IDLE);
  assign launch_err   = err_q;
  assign warp_valid   = (state_q == ST_ISSUE);
  assign warp_sm      = sm_q;
  assign warp_blk_x   = bx_q;
  assign warp_blk_y   = by_q;
  assign warp_id      = w_q;
  assign warp_tid     = THR_W'(w_q) << LG_WARP;
  assign warp_mask    = mask_q;
endmodule

// File: rtl/tbd_chk.sv
module tbd_chk #(
  parameter int NUM_SM = 3,
  parameter int SM_W   = 2,
  parameter int WID_W  = 4,
  parameter int WARP_W = 32,
  parameter int GRID_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              launch_valid,
  input logic              launch_ready,
  input logic              launch_err,
  input logic              warp_valid,
  input logic              warp_ready,
  input logic [SM_W-1:0]   warp_sm,
  input logic [GRID_W-1:0] warp_blk_x,
  input logic [GRID_W-1:0] warp_blk_y,
  input logic [WID_W-1:0]  warp_id,
  input logic [WARP_W-1:0] warp_mask
);
  // R5
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (warp_valid && !warp_ready) |=> (warp_valid && $stable(warp_id) &&
      $stable(warp_sm) && $stable(warp_blk_x) && $stable(warp_blk_y) &&
      $stable(warp_mask)));

  // R5
  warp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (warp_valid && warp_ready) |=> (!warp_valid || warp_id == '0 ||
      warp_id == $past(warp_id) + WID_W'(1)));

  // R3
  mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    warp_valid |-> (warp_mask != '0 &&
      ((warp_mask + WARP_W'(1)) & warp_mask) == '0));

  // R8
  sm_range_chk: assert property (@(posedge clk) disable iff (rst)
    warp_valid |-> (int'(warp_sm) < NUM_SM));

  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    launch_err |-> $past(launch_valid && launch_ready));

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    launch_err |=> !launch_err);
endmodule

bind blk_dispatch tbd_chk #(
  .NUM_SM(NUM_SM), .SM_W(SM_W), .WID_W(WID_W), .WARP_W(WARP_W), .GRID_W(GRID_W)
) u_chk (
  .clk(clk), .rst(rst), .launch_valid(launch_valid), .launch_ready(launch_ready),
  .launch_err(launch_err), .warp_valid(warp_valid), .warp_ready(warp_ready),
  .warp_sm(warp_sm), .warp_blk_x(warp_blk_x), .warp_blk_y(warp_blk_y),
  .warp_id(warp_id), .warp_mask(warp_mask)
);

// File: tb/blk_dispatch_tb_top.sv
module blk_dispatch_tb_top;
  localparam int NSM = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        launch_valid = 1'b0;
  logic        launch_ready;
  logic [5:0]  launch_grid_x = '0, launch_grid_y = '0;
  logic [9:0]  launch_dim_x = '0, launch_dim_y = '0, launch_dim_z = '0;
  logic [7:0]  launch_regs = '0;
  logic        launch_err;
  logic [NSM-1:0] sm_done = '0;
  logic        warp_valid;
  logic        warp_ready = 1'b0;
  logic [1:0]  warp_sm;
  logic [5:0]  warp_blk_x, warp_blk_y;
  logic [3:0]  warp_id;
  logic [9:0]  warp_tid;
  logic [31:0] warp_mask;

  always #10 clk = ~clk;

  blk_dispatch dut_i (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit timeout = 0;
  // bench model
  int k_gx, k_gy, k_thr, k_wlast;
  int m_bx, m_by, m_w, m_sm, m_last = NSM - 1;
  bit m_assigned, kdone, rand_free = 1;
  bit [NSM-1:0] m_busy = '0;

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int exp_mask(int thr, int w);
    int rem = thr - w * 32;
    if (rem >= 32) return -1;
    return (1 << rem) - 1;
  endfunction

  function automatic int rr_pick();
    for (int k = 1; k <= NSM; k++) begin
      int idx = (m_last + k) % NSM;
      if (!m_busy[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) timeout = 1;
    sm_done = '0;
    if (warp_valid && !kdone) begin
      if (!m_assigned) begin
        int e = rr_pick();
        check(int'(warp_sm) == e, "R8 slot choice", int'(warp_sm), e);
        m_sm = e; m_last = e; m_busy[e] = 1'b1; m_assigned = 1;
      end
      check(int'(warp_sm) == m_sm, "R7 same slot", int'(warp_sm), m_sm);
      check(int'(warp_blk_x) == m_bx, "R6 block x", int'(warp_blk_x), m_bx);
      check(int'(warp_blk_y) == m_by, "R6 block y", int'(warp_blk_y), m_by);
      check(int'(warp_id) == m_w, "R5 warp id", int'(warp_id), m_w);
      check(int'(warp_tid) == m_w * 32, "R4 lane0 tid", int'(warp_tid), m_w * 32);
      check(int'(warp_mask) == exp_mask(k_thr, m_w), "R3 mask",
            int'(warp_mask), exp_mask(k_thr, m_w));
      check(!launch_ready, "R10 busy", int'(launch_ready), 0);
      warp_ready = ($urandom_range(0, 3) != 0);
      if (warp_ready) begin
        if (m_w == k_wlast) begin
          m_w = 0; m_assigned = 0;
          if (m_bx == k_gx - 1) begin
            m_bx = 0;
            if (m_by == k_gy - 1) kdone = 1; else m_by++;
          end else m_bx++;
        end else m_w++;
      end
    end else warp_ready = $urandom_range(0, 1);
    if (rand_free && ((warp_valid && $urandom_range(0, 3) == 0) || m_busy == '1)) begin
      int s = $urandom_range(0, NSM - 1);
      for (int k = 0; k < NSM; k++) begin
        if (m_busy[(s + k) % NSM]) begin
          sm_done[(s + k) % NSM] = 1'b1;
          m_busy[(s + k) % NSM] = 1'b0;
          break;
        end
      end
    end
  endtask

  task automatic start_kernel(int gx, int gy, int dx, int dy, int dz, int regs);
    while (!launch_ready && !timeout) tick();
    k_gx = gx; k_gy = gy; k_thr = dx * dy * dz; k_wlast = (k_thr + 31) / 32 - 1;
    m_bx = 0; m_by = 0; m_w = 0; m_assigned = 0; kdone = 0;
    launch_valid = 1'b1;
    launch_grid_x = 6'(gx); launch_grid_y = 6'(gy);
    launch_dim_x = 10'(dx); launch_dim_y = 10'(dy); launch_dim_z = 10'(dz);
    launch_regs = 8'(regs);
    tick();
    launch_valid = 1'b0;
    check(!launch_err, "R2 accepted launch", int'(launch_err), 0);
  endtask

  task automatic finish_kernel();
    while (!kdone && !timeout) tick();
    tick();
    check(launch_ready, "R10 ready after last warp", int'(launch_ready), 1);
  endtask

  task automatic reject(int gx, int gy, int dx, int dy, int dz, int regs, string req);
    while (!launch_ready && !timeout) tick();
    launch_valid = 1'b1;
    launch_grid_x = 6'(gx); launch_grid_y = 6'(gy);
    launch_dim_x = 10'(dx); launch_dim_y = 10'(dy); launch_dim_z = 10'(dz);
    launch_regs = 8'(regs);
    tick();
    launch_valid = 1'b0;
    check(launch_err, req, int'(launch_err), 1);
    tick();
    check(!launch_err, "R11 single pulse", int'(launch_err), 0);
    check(launch_ready && !warp_valid, req, int'(warp_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(launch_ready && !warp_valid && !launch_err, "reset state",
          int'({launch_ready, warp_valid, launch_err}), 4);
    rst = 1'b0;

    start_kernel(2, 2, 40, 1, 1, 16); finish_kernel();   // R3 partial, R6, R9
    start_kernel(3, 1, 4, 4, 2, 20);  finish_kernel();   // R3 3-D exact warp
    start_kernel(1, 1, 8, 8, 8, 16);  finish_kernel();   // R2 exactly 8192
    reject(1, 1, 513, 1, 1, 1, "R1 oversize block");
    reject(1, 1, 16, 16, 1, 33, "R2 register budget");
    reject(2, 1, 4, 0, 1, 1, "R1 zero dimension");
    reject(0, 1, 4, 1, 1, 1, "R1 zero grid");

    for (int i = 0; i < 20 && !timeout; i++) begin
      int dx = $urandom_range(1, 16), dy = $urandom_range(1, 8), dz = $urandom_range(1, 4);
      int mr = 8192 / (dx * dy * dz);
      start_kernel($urandom_range(1, 3), $urandom_range(1, 3), dx, dy, dz,
                   $urandom_range(1, (mr > 255) ? 255 : mr));
      finish_kernel();
    end

    // R9: fill every slot, then free one that is not next in rotation
    tick(); sm_done = '1; m_busy = '0;
    tick(); rand_free = 0;
    start_kernel(3, 1, 32, 1, 1, 8); finish_kernel();
    start_kernel(1, 1, 64, 1, 1, 8);
    repeat (4) begin
      tick();
      check(!warp_valid, "R9 waits for free slot", int'(warp_valid), 0);
    end
    begin
      int s = (m_last + 2) % NSM;
      sm_done[s] = 1'b1; m_busy[s] = 1'b0;
      tick();
      check(!warp_valid, "R9 one cycle after done", int'(warp_valid), 0);
      tick();
      check(warp_valid, "R9 two cycles after done", int'(warp_valid), 1);
      check(int'(warp_sm) == s, "R9 freed slot taken", int'(warp_sm), s);
    end
    finish_kernel();
    rand_free = 1;

    if (timeout) check(0, "watchdog", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule